// File: doc/BRIEF.md
# RTC Alarm and Periodic Interrupt Unit

This block is the interrupt section of a real-time clock. The time counters feed it the current day of the week, hour and minute, all in BCD. It holds two alarm settings. The weekly alarm needs the day of the week, the hour and the minute to agree. The daily alarm needs only the hour and the minute to agree. The block also raises a periodic interrupt. The period comes from a set of tick strobes that a prescaler elsewhere produces, and the interrupt runs in either a pulse mode or a level mode.

Software reaches the block through a small register port. There is a one-cycle write strobe with an address and a data byte, and a combinational read path. A control byte holds the two alarm enables and a 3-bit period select. A status byte carries one flag for each source. Two active-low pins carry the interrupts. Pin B belongs to the weekly alarm alone. Pin A is shared by the daily alarm and the periodic source: it is low while either of them asserts it. Because each source has its own flag, software can tell which one is holding pin A.

Top module: `rtc_alarm_irq`

## Requirements
- R1: The weekly flag (status bit 1) sets one cycle after the day-of-week, hour and minute inputs all become equal to the programmed weekly values. The weekly registers are minute at 0x8, hour at 0x9 and day-of-week at 0xA (bits 2:0).
- R2: The daily flag (status bit 0) sets one cycle after the hour and minute inputs become equal to the programmed daily values, whatever the day of the week. The daily registers are minute at 0xB and hour at 0xC.
- R3: An alarm flag sets only in the cycle in which a match begins. While the same match simply persists, a flag that has been cleared stays clear.
- R4: intBN is low exactly when the weekly flag and the weekly enable are both set. intAN is low when the daily flag and the daily enable are both set, or when the periodic source asserts it, or both.
- R5: The control register at 0xE has bit 7 as the weekly enable, bit 6 as the daily enable and bits 2:0 as the period select. Bits 5:3 read as 0.
- R6: The status register at 0xF returns the daily flag in bit 0, the weekly flag in bit 1 and the periodic flag in bit 2, combinationally in the cycle of the read. Bits 7:3 read as 0.
- R7: Writing 0 to a status bit clears that flag, and writing 1 leaves it unchanged. If a new event arrives in the same cycle as a clear, the flag is left set.
- R8: Clearing an enable bit releases that source's pin in the cycle after the write, and the source's flag keeps its value.
- R9: Period select 000 disables the periodic source: ticks set no flag and do not pull the pin low. The tick input bits are bit 0 = 2 Hz, bit 1 = 1 Hz, bit 2 = minute, bit 3 = hour, bit 4 = day and bit 5 = month. Select 001 uses bit 0, 010 and 011 use bit 1, and 100 to 111 use bits 2 to 5 in turn. A tick on an unselected bit has no effect.
- R10: Selects 001 and 010 are pulse mode. Each selected tick sets the periodic flag and drives intAN low for exactly PulseCycles cycles, starting in the cycle after the tick. The flag has no effect on the pulse.
- R11: Selects 011 to 111 are level mode. A selected tick sets the periodic flag, and intAN stays low until software clears that flag.
- R12: After reset the control byte and the flags are 0 and both pins are high. The alarm hour and minute registers read 0xFF, and the day-of-week register reads 0x07, so no valid time can match them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| curDow | input | 3 | Current day of week (0 to 6) |
| curHour | input | 8 | Current hour, BCD |
| curMin | input | 8 | Current minute, BCD |
| periodTicks | input | 6 | One-cycle tick strobes: 2 Hz, 1 Hz, minute, hour, day, month |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | 8 | Read data, combinational |
| intAN | output | 1 | Daily alarm or periodic interrupt, active low |
| intBN | output | 1 | Weekly alarm interrupt, active low |

## Verification
The assertions assume two things about the inputs. First, the tick strobes last one cycle and are spaced further apart than PulseCycles. Second, the time inputs are valid BCD, so the invalid reset values of the alarm registers never match. The bench keeps to both. It drives each tick for a single cycle with idle cycles around it. It draws the random times only from a few valid BCD values near the programmed alarms, so that matches begin, persist and end often. Random flag-clear writes fall on arbitrary cycles, so some of them land together with the start of a match.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int DataW    = 8;
  localparam int AddrW    = 4;
  localparam int DowW     = 3;
  localparam int NumTicks = 6;

  localparam logic [AddrW-1:0] AddrWMin  = 4'h8;
  localparam logic [AddrW-1:0] AddrWHour = 4'h9;
  localparam logic [AddrW-1:0] AddrWDow  = 4'hA;
  localparam logic [AddrW-1:0] AddrDMin  = 4'hB;
  localparam logic [AddrW-1:0] AddrDHour = 4'hC;
  localparam logic [AddrW-1:0] AddrCtrl  = 4'hE;
  localparam logic [AddrW-1:0] AddrStat  = 4'hF;

  typedef struct packed {
    logic wMin;
    logic wHour;
    logic wDow;
    logic dMin;
    logic dHour;
  } alarmWrT;
endpackage

// File: rtl/rtc_irq_alarm_dp.sv
module rtc_irq_alarm_dp
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  alarmWrT          strb,
  input  logic [DataW-1:0] wrData,
  input  logic [DowW-1:0]  curDow,
  input  logic [DataW-1:0] curHour,
  input  logic [DataW-1:0] curMin,
  input  logic [AddrW-1:0] rdAddr,
  output logic             weekHit,
  output logic             dayHit,
  output logic [DataW-1:0] rdAlarm
);
  localparam int NumCh = 2;  // channel 0 = daily, 1 = weekly

  logic [DataW-1:0] almMin [NumCh];
  logic [DataW-1:0] almHour[NumCh];
  logic [DowW-1:0]  almDow;
  logic [NumCh-1:0] hmMatch, fullMatch, prevMatch, hitVec;
  logic [NumCh-1:0] wrMinVec, wrHourVec;

  assign wrMinVec  = {strb.wMin, strb.dMin};
  assign wrHourVec = {strb.wHour, strb.dHour};

  for (genvar ch = 0; ch < NumCh; ch++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        almMin[ch]  <= '1;
        almHour[ch] <= '1;
      end else begin
        if (wrMinVec[ch])  almMin[ch]  <= wrData;
        if (wrHourVec[ch]) almHour[ch] <= wrData;
      end
    end
    assign hmMatch[ch] = (curMin == almMin[ch]) && (curHour == almHour[ch]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          almDow <= '1;
    else if (strb.wDow) almDow <= wrData[DowW-1:0];
  end

  assign fullMatch = {hmMatch[1] && (curDow == almDow), hmMatch[0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevMatch <= '0;
    else       prevMatch <= fullMatch;
  end

  assign hitVec  = fullMatch & ~prevMatch;
  assign dayHit  = hitVec[0];
  assign weekHit = hitVec[1];

  always_comb begin
    unique case (rdAddr)
      AddrWMin:  rdAlarm = almMin[1];
      AddrWHour: rdAlarm = almHour[1];
      AddrWDow:  rdAlarm = {{(DataW-DowW){1'b0}}, almDow};
      AddrDMin:  rdAlarm = almMin[0];
      AddrDHour: rdAlarm = almHour[0];
      default:   rdAlarm = '0;
    endcase
  end

  // A match has to end before it can begin again
  assert_week_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    weekHit |=> !weekHit);
  assert_day_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    dayHit |=> !dayHit);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int PulseCycles = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [AddrW-1:0]    wrAddr,
  input  logic [DataW-1:0]    wrData,
  input  logic [NumTicks-1:0] periodTicks,
  input  logic                weekHit,
  input  logic                dayHit,
  output alarmWrT             strb,
  output logic                intAN,
  output logic                intBN,
  output logic [DataW-1:0]    ctrlByte,
  output logic [DataW-1:0]    statByte
);
  localparam int CntW = $clog2(PulseCycles + 1);

  logic            wEn, dEn;
  logic [2:0]      perSel;
  logic            flagD, flagW, flagP;
  logic            ctrlWr, statWr, selTick, perHit, pulseMode, levelMode;
  logic [CntW-1:0] pulseCnt;

  assign ctrlWr = wrEn && (wrAddr == AddrCtrl);
  assign statWr = wrEn && (wrAddr == AddrStat);

  always_comb begin
    strb       = '0;
    strb.wMin  = wrEn && (wrAddr == AddrWMin);
    strb.wHour = wrEn && (wrAddr == AddrWHour);
    strb.wDow  = wrEn && (wrAddr == AddrWDow);
    strb.dMin  = wrEn && (wrAddr == AddrDMin);
    strb.dHour = wrEn && (wrAddr == AddrDHour);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wEn <= 1'b0; dEn <= 1'b0; perSel <= '0;
    end else if (ctrlWr) begin
      wEn <= wrData[7]; dEn <= wrData[6]; perSel <= wrData[2:0];
    end
  end

  always_comb begin
    unique case (perSel)
      3'd0:       selTick = 1'b0;
      3'd1:       selTick = periodTicks[0];
      3'd2, 3'd3: selTick = periodTicks[1];
      default:    selTick = periodTicks[perSel - 3'd2];
    endcase
  end

  assign pulseMode = (perSel == 3'd1) || (perSel == 3'd2);
  assign levelMode = perSel >= 3'd3;
  assign perHit    = selTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagD <= 1'b0; flagW <= 1'b0; flagP <= 1'b0;
    end else begin
      flagD <= dayHit  || (flagD && !(statWr && !wrData[0]));
      flagW <= weekHit || (flagW && !(statWr && !wrData[1]));
      flagP <= perHit  || (flagP && !(statWr && !wrData[2]));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  pulseCnt <= '0;
    else if (!pulseMode)        pulseCnt <= '0;
    else if (perHit)            pulseCnt <= CntW'(PulseCycles);
    else if (pulseCnt != '0)    pulseCnt <= pulseCnt - 1'b1;
  end

  assign intBN    = !(wEn && flagW);
  assign intAN    = !((dEn && flagD) || (pulseMode && pulseCnt != '0) || (levelMode && flagP));
  assign ctrlByte = {wEn, dEn, 3'b000, perSel};
  assign statByte = {5'b0, flagP, flagW, flagD};

  assert_week_flag_src_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagW) |-> $past(weekHit));
  assert_day_flag_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagD) |-> $past(dayHit));
  assert_write_one_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && wrData[1] && flagW) |=> flagW);
  assert_disable_releases_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wEn) |-> intBN);
  assert_off_no_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagP) |-> $past(perSel != 3'd0));
  assert_pulse_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= CntW'(PulseCycles));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_irq_pkg::*;
#(
  parameter int PulseCycles = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          curDow,
  input  logic [7:0]          curHour,
  input  logic [7:0]          curMin,
  input  logic [5:0]          periodTicks,
  input  logic                wrEn,
  input  logic [3:0]          wrAddr,
  input  logic [7:0]          wrData,
  input  logic [3:0]          rdAddr,
  output logic [7:0]          rdData,
  output logic                intAN,
  output logic                intBN
);
  alarmWrT          strb;
  logic             weekHit, dayHit;
  logic [DataW-1:0] rdAlarm, ctrlByte, statByte;

  rtc_irq_ctrl #(.PulseCycles(PulseCycles)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .periodTicks(periodTicks), .weekHit(weekHit), .dayHit(dayHit),
    .strb(strb), .intAN(intAN), .intBN(intBN),
    .ctrlByte(ctrlByte), .statByte(statByte)
  );

  rtc_irq_alarm_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .curDow(curDow), .curHour(curHour), .curMin(curMin), .rdAddr(rdAddr),
    .weekHit(weekHit), .dayHit(dayHit), .rdAlarm(rdAlarm)
  );

  always_comb begin
    if (rdAddr == AddrCtrl)      rdData = ctrlByte;
    else if (rdAddr == AddrStat) rdData = statByte;
    else                         rdData = rdAlarm;
  end
endmodule

// File: tb/rtc_alarm_irq_test.sv
module rtc_alarm_irq_test;
  localparam int ClkPeriod = 10;
  localparam int Pulse = 4;

  logic clk = 0, rstN = 0;
  logic [2:0] curDow = 0;
  logic [7:0] curHour = 8'h00, curMin = 8'h00;
  logic [5:0] periodTicks = 0;
  logic wrEn = 0;
  logic [3:0] wrAddr = 0, rdAddr = 4'hF;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic intAN, intBN;
  int total = 0, bad = 0;

  rtc_alarm_irq #(.PulseCycles(Pulse)) uut (.*);

  always #(ClkPeriod/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(posedge clk); #1 wrEn = 0;
  endtask

  task automatic setTime(logic [2:0] dw, logic [7:0] h, logic [7:0] m);
    @(negedge clk); curDow = dw; curHour = h; curMin = m;
    @(posedge clk); #1;
  endtask

  task automatic tick(int b);
    @(negedge clk); periodTicks[b] = 1;
    @(posedge clk); #1 periodTicks = 0;
  endtask

  function automatic bit mW(logic [2:0] d, logic [7:0] h, logic [7:0] m);
    return d == 3'd2 && h == 8'h11 && m == 8'h45;
  endfunction
  function automatic bit mD(logic [7:0] h, logic [7:0] m);
    return h == 8'h11 && m == 8'h46;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lows;
    bit pW, pD, fW, fD;
    void'($urandom(32'd1234));
    curHour = 8'h23; curMin = 8'h59;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;
    // R12 reset state
    rdAddr = 4'hE; #1 chk("R12 ctrl", rdData, 0);
    rdAddr = 4'hF; #1 chk("R12 status", rdData, 0);
    chk("R12 pinA", intAN, 1); chk("R12 pinB", intBN, 1);
    rdAddr = 4'h8; #1 chk("R12 wmin", rdData, 8'hFF);
    rdAddr = 4'hA; #1 chk("R12 wdow", rdData, 8'h07);

    // program alarms, R5 readback
    wr(4'h8, 8'h30); wr(4'h9, 8'h07); wr(4'hA, 8'h05);
    wr(4'hB, 8'h30); wr(4'hC, 8'h07);
    rdAddr = 4'h9; #1 chk("R1 whour readback", rdData, 8'h07);
    wr(4'hE, 8'hFF);
    rdAddr = 4'hE; #1 chk("R5 ctrl readback", rdData, 8'hC7);
    wr(4'hE, 8'hC0);
    rdAddr = 4'hF;

    // R2 daily match on other day
    setTime(3'd3, 8'h07, 8'h30);
    #1 chk("R2 daily flag", rdData, 8'h01);
    chk("R4 pinA low", intAN, 0); chk("R4 pinB high", intBN, 1);
    // R1 weekly on day change; daily continuous
    setTime(3'd5, 8'h07, 8'h30);
    #1 chk("R1 weekly flag", rdData, 8'h03);
    chk("R4 pinB low", intBN, 0);
    // R7 write 1 keeps, 0 clears
    wr(4'hF, 8'hFE);
    #1 chk("R7 clear daily only", rdData, 8'h02);
    chk("R7 pinA released", intAN, 1);
    // R3 persistent match does not re-set
    repeat (3) @(posedge clk);
    #1 chk("R3 no reset on persist", rdData, 8'h02);
    // R8 disable weekly enable
    wr(4'hE, 8'h40);
    #1 chk("R8 pinB released", intBN, 1);
    chk("R8 flag kept", rdData, 8'h02);
    wr(4'hF, 8'h00);
    // R7 set wins over clear
    setTime(3'd5, 8'h07, 8'h31);
    @(negedge clk); curMin = 8'h30; wrEn = 1; wrAddr = 4'hF; wrData = 8'h00;
    @(posedge clk); #1 wrEn = 0;
    #1 chk("R7 set beats clear", rdData[1:0], 2'b11);
    wr(4'hF, 8'h00);
    setTime(3'd0, 8'h00, 8'h00);

    // R9 off: ticks ignored
    wr(4'hE, 8'h00);
    tick(1); tick(0);
    #1 chk("R9 off no flag", rdData, 0); chk("R9 off pin", intAN, 1);
    // R10 pulse mode 2 Hz
    wr(4'hE, 8'h01);
    tick(1);
    #1 chk("R9 unselected tick", rdData, 0);
    @(negedge clk); periodTicks[0] = 1;
    @(posedge clk); #1 periodTicks = 0;
    lows = 0;
    for (int i = 0; i < 8; i++) begin
      if (!intAN) lows++;
      if (i == 1) wr(4'hF, 8'h00); else begin @(posedge clk); #1; end
    end
    chk("R10 pulse length", lows, Pulse);
    tick(0);
    #1 chk("R10 flag in pulse", rdData, 8'h04);
    repeat (Pulse + 1) @(posedge clk);
    #1 wr(4'hF, 8'h00);
    // R11 level mode per minute (select 100 -> bit 2)
    wr(4'hE, 8'h04);
    tick(1);
    #1 chk("R9 sec ignored for minute", rdData, 0);
    tick(2);
    #1 chk("R11 flag", rdData, 8'h04); chk("R11 pin low", intAN, 0);
    repeat (5) @(posedge clk);
    #1 chk("R11 still low", intAN, 0);
    wr(4'hF, 8'hFB);
    #1 chk("R11 released", intAN, 1);
    // R9 month select
    wr(4'hE, 8'h07); tick(5);
    #1 chk("R9 month", rdData, 8'h04);
    wr(4'hF, 8'h00);

    // random phase against model (R1 R2 R3 R4 R6 R7)
    wr(4'h8, 8'h45); wr(4'h9, 8'h11); wr(4'hA, 8'h02);
    wr(4'hB, 8'h46); wr(4'hC, 8'h11);
    wr(4'hE, 8'hC0);
    setTime(3'd0, 8'h00, 8'h00);
    wr(4'hF, 8'h00);
    pW = 0; pD = 0; fW = 0; fD = 0;
    for (int n = 0; n < 400; n++) begin
      bit hW, hD, clr;
      logic [1:0] cd;
      @(negedge clk);
      curDow  = ($urandom % 2) ? 3'd2 : 3'd3;
      curHour = ($urandom % 4 != 0) ? 8'h11 : 8'h12;
      curMin  = ($urandom % 2) ? 8'h45 : 8'h46;
      clr = ($urandom % 6) == 0;
      cd = 2'($urandom);
      wrEn = clr; wrAddr = 4'hF; wrData = {6'b0, cd};
      hW = mW(curDow, curHour, curMin) && !pW;
      hD = mD(curHour, curMin) && !pD;
      pW = mW(curDow, curHour, curMin); pD = mD(curHour, curMin);
      fW = hW || (fW && !(clr && !cd[1]));
      fD = hD || (fD && !(clr && !cd[0]));
      @(posedge clk); #1 wrEn = 0;
      #1;
      chk("R6 random status", rdData, {6'b0, fW, fD});
      chk("R4 random pinB", intBN, !fW);
      chk("R4 random pinA", intAN, !fD);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule